// File: doc/BRIEF.md
# SCL Clock Phase Generator

This block generates the low and high phases of an I2C serial clock from a peripheral clock. A 3-bit select divides the peripheral clock by a power of two to form a reference tick. Two 5-bit counts set the length of the low phase and the length of the high phase in reference ticks. Each phase also gets a fixed number of extra ticks, which stand in for the input synchronizer and the glitch filter. That number depends on whether the divider is bypassed.

The block pulls SCL low for the low phase and then releases it. It starts timing the high phase only once the synchronized and filtered SCL input reads high, so a slave that holds the line low stretches the clock. The byte engine starts clocking with a start pulse and ends it with a stop pulse. The block returns two one-cycle strobes, one at the start of each phase. The prescale select and both counts are sampled at each phase entry, so a change never shortens or lengthens a phase that is already running.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset the block is idle: `scl_drive_low`, `lo_start` and `hi_start` are 0, and no phase starts without a start pulse.
- R2: A `start_req` pulse while idle makes `scl_drive_low` and `lo_start` both 1 in the next cycle. `lo_start` lasts one cycle. If `stop_req` is high in the same cycle, the start is ignored and the block stays idle.
- R3: With prescale select 0, every low phase keeps `scl_drive_low` at 1 for exactly (low count + 4) clock cycles.
- R4: With prescale select s > 0, every phase lasts (count + 3) × 2^s clock cycles.
- R5: The high phase begins with a one-cycle `hi_start` while `scl_drive_low` is 0. The next `lo_start` follows exactly (high count + extra) × 2^s cycles after the `hi_start` cycle, where extra is 4 for s = 0 and 3 otherwise. `lo_start` and `hi_start` are never 1 together.
- R6: While SCL is held low after the low phase ends, `hi_start` stays 0. Once `scl_in` goes high, `hi_start` appears in the fifth cycle after that.
- R7: A high pulse on `scl_in` that lasts one cycle does not start the high phase.
- R8: A count of 0 is treated as 1, so the shortest phase with select 0 is 5 cycles. No low phase is shorter than 5 cycles.
- R9: A change to either count takes effect at the next entry into that phase. The phase already running keeps the length it had when it began.
- R10: A `start_req` pulse while clocking has no effect. A `stop_req` pulse while clocking lets the current or next high phase finish, then the block goes idle with SCL released and no further `lo_start`. This includes a stop that arrives in the last cycle of a high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_sel | input | 3 | Selects a reference tick of clk / 2^presc_sel |
| low_cnt | input | 5 | Low phase count, in reference ticks |
| high_cnt | input | 5 | High phase count, in reference ticks |
| start_req | input | 1 | Pulse from the byte engine that begins clocking |
| stop_req | input | 1 | Pulse from the byte engine that ends clocking |
| scl_in | input | 1 | Raw SCL level seen on the bus |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| lo_start | output | 1 | One-cycle strobe in the first cycle of a low phase |
| hi_start | output | 1 | One-cycle strobe in the first cycle of a high phase |

## Verification
Two events can land in the same cycle: the final reference tick of a high phase and a stop pulse from the byte engine. If the stop were missed, a new low phase would start. The bench counts off the exact length of a high phase from its `hi_start`, then raises `stop_req` in that final cycle. It judges the result by checking that the next cycle shows neither `lo_start` nor a driven-low SCL, and that no low phase follows. The other same-cycle case is a start pulse together with a stop pulse while idle. It is judged by the absence of any low phase.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_WAITH = 2'd2,
    PH_HIGH  = 2'd3
  } phase_e;

  // extra reference ticks folded into every phase
  localparam int unsigned EXTRA_BYPASS = 4;
  localparam int unsigned EXTRA_DIV    = 3;
endpackage

// File: rtl/scl_in_filter.sv
module scl_in_filter #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  output logic scl_filt
);
  logic [SYNC_STAGES:0] chain_q;
  logic                 filt_q;
  logic                 filt_d;
  logic                 filt_en;

  // synchronizer plus one extra stage for the agreement test
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], scl_raw};
  end

  // level updates only when two consecutive samples agree
  always_comb begin
    filt_en = (chain_q[SYNC_STAGES] == chain_q[SYNC_STAGES-1]);
    filt_d  = chain_q[SYNC_STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       filt_q <= 1'b1;
    else if (filt_en) filt_q <= filt_d;
  end

  assign scl_filt = filt_q;
endmodule

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;
  localparam logic [DIV_W:0]   ONE_W = 1;
  localparam logic [DIV_W-1:0] INC   = 1;

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   lim_w;

  always_comb begin
    lim_w = (ONE_W << sel) - ONE_W;
    tick  = (cnt_q == lim_w[DIV_W-1:0]);
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_q + INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             lo_start,
  output logic             hi_start
);
  import sclgen_pkg::*;

  localparam int unsigned TGT_W = CNT_W + 1;
  localparam logic [TGT_W-1:0] T_ONE = 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic scl_filt;
  logic tick;
  logic enter_low, enter_high;
  logic cfg_en;

  phase_e           ph_q, ph_d;
  logic [TGT_W-1:0] tcnt_q, tcnt_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             stop_pend_q, stop_pend_d;
  logic             lo_start_q, hi_start_q;
  logic             last_tick;

  scl_in_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .scl_raw  (scl_in),
    .scl_filt (scl_filt)
  );

  ref_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (cfg_en),
    .sel   (sel_q),
    .tick  (tick)
  );

  function automatic logic [TGT_W-1:0] phase_target(input logic [CNT_W-1:0] n,
                                                     input logic [SEL_W-1:0] s);
    logic [TGT_W-1:0] base;
    base = (n == '0) ? T_ONE : {1'b0, n};
    if (s == '0) return base + TGT_W'(EXTRA_BYPASS);
    else         return base + TGT_W'(EXTRA_DIV);
  endfunction

  always_comb begin
    ph_d        = ph_q;
    tcnt_d      = tcnt_q;
    tgt_d       = tgt_q;
    sel_d       = sel_q;
    stop_pend_d = stop_pend_q;
    enter_low   = 1'b0;
    enter_high  = 1'b0;
    last_tick   = tick && (tcnt_q == (tgt_q - T_ONE));

    unique case (ph_q)
      PH_IDLE: begin
        stop_pend_d = 1'b0;
        if (start_req && !stop_req) enter_low = 1'b1;
      end
      PH_LOW: begin
        if (stop_req) stop_pend_d = 1'b1;
        if (last_tick)  ph_d   = PH_WAITH;
        else if (tick)  tcnt_d = tcnt_q + T_ONE;
      end
      PH_WAITH: begin
        if (stop_req) stop_pend_d = 1'b1;
        if (scl_filt) enter_high = 1'b1;
      end
      PH_HIGH: begin
        if (stop_req) stop_pend_d = 1'b1;
        if (last_tick) begin
          if (stop_pend_q || stop_req) begin
            ph_d        = PH_IDLE;
            stop_pend_d = 1'b0;
          end else begin
            enter_low = 1'b1;
          end
        end else if (tick) begin
          tcnt_d = tcnt_q + T_ONE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase

    cfg_en = enter_low || enter_high;
    if (enter_low) begin
      ph_d  = PH_LOW;
      tgt_d = phase_target(low_cnt, presc_sel);
    end
    if (enter_high) begin
      ph_d  = PH_HIGH;
      tgt_d = phase_target(high_cnt, presc_sel);
    end
    if (cfg_en) begin
      sel_d  = presc_sel;
      tcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ph_q        <= PH_IDLE;
      tcnt_q      <= '0;
      stop_pend_q <= 1'b0;
      lo_start_q  <= 1'b0;
      hi_start_q  <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      tcnt_q      <= tcnt_d;
      stop_pend_q <= stop_pend_d;
      lo_start_q  <= enter_low;
      hi_start_q  <= enter_high;
    end
  end

  // phase settings load only on a phase entry
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tgt_q <= T_ONE;
      sel_q <= '0;
    end else if (cfg_en) begin
      tgt_q <= tgt_d;
      sel_q <= sel_d;
    end
  end

  assign scl_drive_low = (ph_q == PH_LOW);
  assign lo_start      = lo_start_q;
  assign hi_start      = hi_start_q;
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_drive_low,
  input logic lo_start,
  input logic hi_start,
  input logic scl_filt
);
  logic [7:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run_q <= 8'd0;
    else if (!scl_drive_low) low_run_q <= 8'd0;
    else if (low_run_q != 8'hFF) low_run_q <= low_run_q + 8'd1;
  end

  // R2
  lo_strobe_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_start |-> scl_drive_low);

  // R2
  low_entry_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> lo_start);

  // R5
  hi_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_start |-> !scl_drive_low);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_start, hi_start}));

  // R6
  hi_after_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_start |-> $past(scl_filt));

  // R8
  min_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> (low_run_q >= 8'd5));
endmodule

bind scl_rate_gen sclgen_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_drive_low (scl_drive_low),
  .lo_start      (lo_start),
  .hi_start      (hi_start),
  .scl_filt      (scl_filt)
);

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] presc_sel;
  logic [4:0] low_cnt, high_cnt;
  logic       start_req, stop_req;
  logic       stretch, glitch_hi;
  logic       scl_in;
  logic       scl_drive_low, lo_start, hi_start;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  // open-drain loopback with a slave that may hold the line low
  assign scl_in = glitch_hi | (!scl_drive_low & !stretch);

  scl_rate_gen u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .presc_sel     (presc_sel),
    .low_cnt       (low_cnt),
    .high_cnt      (high_cnt),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .lo_start      (lo_start),
    .hi_start      (hi_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int n, input int s);
    int base;
    base = (n == 0) ? 1 : n;
    return (base + ((s == 0) ? 4 : 3)) * (1 << s);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic quiesce();
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    cyc(1500);
  endtask

  task automatic measure_low(output int len);
    len = 0;
    while (scl_drive_low && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic wait_hi();
    int w;
    w = 0;
    while (!hi_start && w < 5000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic measure_high(output int len);
    len = 0;
    while (!lo_start && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int seen;
    check(!scl_drive_low && !lo_start && !hi_start, "R1 reset outputs",
          {scl_drive_low, lo_start, hi_start}, 0);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (lo_start || scl_drive_low) seen++;
    end
    check(seen == 0, "R1 idle without start", seen, 0);
  endtask

  task automatic t_start_prio();
    int len;
    presc_sel = 3'd0; low_cnt = 5'd5; high_cnt = 5'd6;
    start_req = 1'b1; stop_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0; stop_req = 1'b0;
    check(!scl_drive_low && !lo_start, "R2 start with stop ignored", scl_drive_low, 0);
    cyc(5);
    check(!scl_drive_low, "R2 still idle", scl_drive_low, 0);
    pulse_start();
    check(lo_start && scl_drive_low, "R2 start strobe", {lo_start, scl_drive_low}, 3);
    @(negedge clk);
    check(!lo_start, "R2 strobe one cycle", lo_start, 0);
    measure_low(len);
    check(len == exp_len(5, 0) - 1, "R3 low length sel0", len + 1, exp_len(5, 0));
    wait_hi();
    check(!scl_drive_low, "R5 released at hi_start", scl_drive_low, 0);
    measure_high(len);
    check(len == exp_len(6, 0), "R5 high length sel0", len, exp_len(6, 0));
    measure_low(len);
    check(len == exp_len(5, 0), "R3 second low length", len, exp_len(5, 0));
    quiesce();
  endtask

  task automatic t_prescale();
    int len;
    presc_sel = 3'd2; low_cnt = 5'd2; high_cnt = 5'd3;
    pulse_start();
    measure_low(len);
    check(len == exp_len(2, 2), "R4 low sel2", len, exp_len(2, 2));
    wait_hi();
    measure_high(len);
    check(len == exp_len(3, 2), "R4 high sel2", len, exp_len(3, 2));
    quiesce();
    presc_sel = 3'd7; low_cnt = 5'd1; high_cnt = 5'd1;
    pulse_start();
    measure_low(len);
    check(len == exp_len(1, 7), "R4 low sel7", len, exp_len(1, 7));
    wait_hi();
    measure_high(len);
    check(len == exp_len(1, 7), "R4 high sel7", len, exp_len(1, 7));
    quiesce();
  endtask

  task automatic t_zero();
    int len;
    presc_sel = 3'd0; low_cnt = 5'd0; high_cnt = 5'd0;
    pulse_start();
    measure_low(len);
    check(len == 5, "R8 zero low count", len, 5);
    wait_hi();
    measure_high(len);
    check(len == 5, "R8 zero high count", len, 5);
    quiesce();
  endtask

  task automatic t_update();
    int len;
    presc_sel = 3'd0; low_cnt = 5'd4; high_cnt = 5'd4;
    pulse_start();
    len = 0;
    while (scl_drive_low && len < 5000) begin
      if (len == 2) low_cnt = 5'd10;
      len++;
      @(negedge clk);
    end
    check(len == exp_len(4, 0), "R9 running low kept", len, exp_len(4, 0));
    wait_hi();
    len = 0;
    while (!lo_start && len < 5000) begin
      if (len == 1) high_cnt = 5'd9;
      len++;
      @(negedge clk);
    end
    check(len == exp_len(4, 0), "R9 running high kept", len, exp_len(4, 0));
    measure_low(len);
    check(len == exp_len(10, 0), "R9 new low applied", len, exp_len(10, 0));
    wait_hi();
    measure_high(len);
    check(len == exp_len(9, 0), "R9 new high applied", len, exp_len(9, 0));
    quiesce();
  endtask

  task automatic t_stretch();
    int len, seen, k;
    presc_sel = 3'd0; low_cnt = 5'd2; high_cnt = 5'd2;
    stretch = 1'b1;
    pulse_start();
    measure_low(len);
    check(len == exp_len(2, 0), "R3 low before stretch", len, exp_len(2, 0));
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      if (hi_start || scl_drive_low) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R6 held low no high phase", seen, 0);
    glitch_hi = 1'b1;
    @(negedge clk);
    glitch_hi = 1'b0;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (hi_start) seen++;
    end
    check(seen == 0, "R7 one-cycle glitch ignored", seen, 0);
    stretch = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!hi_start && k < 50);
    check(k == 5, "R6 high phase after release", k, 5);
    measure_high(len);
    check(len == exp_len(2, 0), "R5 high length after stretch", len, exp_len(2, 0));
    quiesce();
  endtask

  task automatic t_stop();
    int len, los, his;
    presc_sel = 3'd0; low_cnt = 5'd3; high_cnt = 5'd3;
    pulse_start();
    len = 0;
    while (scl_drive_low && len < 5000) begin
      start_req = (len == 2);
      len++;
      @(negedge clk);
    end
    start_req = 1'b0;
    check(len == exp_len(3, 0), "R10 start while running ignored", len, exp_len(3, 0));
    wait_hi();
    measure_high(len);
    check(len == exp_len(3, 0), "R10 high before stop", len, exp_len(3, 0));
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    los = 0; his = 0;
    for (int i = 0; i < 300; i++) begin
      if (lo_start) los++;
      if (hi_start) his++;
      @(negedge clk);
    end
    check(los == 0, "R10 no low after stop", los, 0);
    check(his == 1, "R10 high phase completed", his, 1);
    check(!scl_drive_low, "R10 released when idle", scl_drive_low, 0);
    // stop landing on the last high cycle
    pulse_start();
    wait_hi();
    cyc(exp_len(3, 0) - 1);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check(!lo_start && !scl_drive_low, "R10 stop on last high cycle",
          {lo_start, scl_drive_low}, 0);
    los = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (lo_start) los++;
    end
    check(los == 0, "R10 idle after boundary stop", los, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    presc_sel = 3'd0; low_cnt = 5'd1; high_cnt = 5'd1;
    start_req = 1'b0; stop_req = 1'b0;
    stretch = 1'b0; glitch_hi = 1'b0;
    cyc(3);
    check(!scl_drive_low && !lo_start && !hi_start, "R1 in reset",
          {scl_drive_low, lo_start, hi_start}, 0);
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_start_prio();
    t_prescale();
    t_zero();
    t_update();
    t_stretch();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule